// File: doc/BRIEF.md
# Thread ID System Register Bank

This block holds three 32-bit thread-identifier registers that sit inside a processor's system-control coprocessor. Each cycle it can accept one coprocessor transfer instruction word along with a valid strobe. It pulls the coprocessor number, register and opcode fields out of that word and decides whether the word addresses one of its three registers. It then checks the requested direction against the current privilege level. A permitted read places the register's value on the read-data output in the same cycle. A permitted write loads the write data on the next clock edge.

An access is refused with the undefined flag in any of these cases: it breaks the target register's permission, it names a second opcode that selects no register, or the feature enable is clear. A refused access changes no register. Every access goes through one shared field comparison. A per-register permission mask then grants or denies it.

Top module: `tid_reg_bank`

## Requirements
- R1: After reset all three registers read as zero.
- R2: A request belongs to the bank only when all of these hold: instruction bits 11:8 equal 15, bits 19:16 equal 13, bits 3:0 equal 0 and bits 23:21 equal 0. Inside the bank, bits 7:5 pick the register: 2 selects register A, 3 selects B and 4 selects C. Bit 20 set means a read of the register. Bit 20 clear means a write of it.
- R3: Register A can be read and written from both user mode and privileged mode.
- R4: Register B can be read from either mode. A user-mode write to B raises the undefined flag and leaves B unchanged. A privileged write to B succeeds.
- R5: Register C is reachable only from privileged mode. A user-mode read or write of C raises the undefined flag and returns zero read data.
- R6: A bank request whose bits 7:5 are not 2, 3 or 4 raises the undefined flag.
- R7: While the feature enable is low, every bank request raises the undefined flag and no register changes.
- R8: A permitted write updates the register at the clock edge that ends the request cycle. A permitted read drives the register value on the read data in the request cycle itself. In every other cycle the read data is zero.
- R9: The undefined flag is high only during a valid bank request that is refused. A refused request changes no register.
- R10: A valid request outside the bank raises no flag, changes no register and returns zero read data. So does any cycle with the valid strobe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instrValid | input | 1 | Instruction word is presented this cycle |
| instr | input | 32 | Coprocessor transfer instruction word |
| privMode | input | 1 | 1 = privileged, 0 = user |
| featEn | input | 1 | Thread-ID feature present |
| wrData | input | 32 | Data to write into the selected register |
| rdData | output | 32 | Value read from the selected register, zero otherwise |
| undefFlag | output | 1 | Refused access to the bank's encodings |

## Verification
Permission rejection and the register write strobe are decided in the same cycle. A refused write must raise the flag and suppress the store at the same time. The bench forces this with user-mode writes to B and C and with writes issued while the feature enable is low. It judges the result in two ways: the flag in the request cycle, and a later privileged read that must still return the old value. Random traffic also puts a read and the flag into the same cycle for C, and there the read data must be zero.

// File: rtl/tid_pkg.sv
package tid_pkg;
  localparam int NUM_TID = 3;
  localparam int SEL_W   = $clog2(NUM_TID);

  typedef struct packed {
    logic [3:0] cpNum;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op1;
    logic [2:0] op2;
    logic       isRead;
  } tidFields_t;

  typedef struct packed {
    logic [NUM_TID-1:0] wrEn;
    logic               rdEn;
    logic [SEL_W-1:0]   rdSel;
  } tidCtl_t;
endpackage

// File: rtl/tid_decode.sv
module tid_decode
  import tid_pkg::*;
(
  input  logic [31:0] instr,
  output tidFields_t  fields
);
  always_comb begin
    fields.cpNum  = instr[11:8];
    fields.crn    = instr[19:16];
    fields.crm    = instr[3:0];
    fields.op1    = instr[23:21];
    fields.op2    = instr[7:5];
    fields.isRead = instr[20];
  end
endmodule

// File: rtl/tid_ctrl.sv
module tid_ctrl
  import tid_pkg::*;
#(
  parameter logic [3:0]         CP_ID    = 4'd15,
  parameter logic [3:0]         CRN_ID   = 4'd13,
  parameter logic [3:0]         CRM_ID   = 4'd0,
  parameter logic [2:0]         OP1_ID   = 3'd0,
  parameter int                 OP2_BASE = 2,
  parameter logic [NUM_TID-1:0] USER_RD  = 3'b011,
  parameter logic [NUM_TID-1:0] USER_WR  = 3'b001
)(
  input  logic       instrValid,
  input  tidFields_t fields,
  input  logic       privMode,
  input  logic       featEn,
  output tidCtl_t    ctl,
  output logic       undefFlag
);
  logic [NUM_TID-1:0] sel;
  logic groupHit, anySel, permOk, allowed;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TID; gi++) begin : g_sel
      assign sel[gi] = (fields.op2 == 3'(OP2_BASE + gi));
    end
  endgenerate

  always_comb begin
    groupHit = instrValid && (fields.cpNum == CP_ID) && (fields.crn == CRN_ID)
               && (fields.crm == CRM_ID) && (fields.op1 == OP1_ID);
    anySel   = |sel;
    if (privMode) permOk = 1'b1;
    else if (fields.isRead) permOk = |(sel & USER_RD);
    else permOk = |(sel & USER_WR);
    allowed   = groupHit && featEn && anySel && permOk;
    undefFlag = groupHit && !allowed;
  end

  always_comb begin
    ctl.wrEn  = (allowed && !fields.isRead) ? sel : '0;
    ctl.rdEn  = allowed && fields.isRead;
    ctl.rdSel = '0;
    for (int i = 0; i < NUM_TID; i++) begin
      if (sel[i]) ctl.rdSel = SEL_W'(i);
    end
  end
endmodule

// File: rtl/tid_datapath.sv
module tid_datapath
  import tid_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic                           clk,
  input  logic                           rstN,
  input  tidCtl_t                        ctl,
  input  logic [DATA_W-1:0]              wrData,
  output logic [DATA_W-1:0]              rdData,
  output logic [NUM_TID-1:0][DATA_W-1:0] regBank
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_TID; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regBank[gi] <= '0;
        else if (ctl.wrEn[gi]) regBank[gi] <= wrData;
      end
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (ctl.rdEn && (int'(ctl.rdSel) < NUM_TID)) rdData = regBank[ctl.rdSel];
  end
endmodule

// File: rtl/tid_reg_bank.sv
module tid_reg_bank
  import tid_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [31:0]       instr,
  input  logic              privMode,
  input  logic              featEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              undefFlag
);
  tidFields_t fields;
  tidCtl_t    ctl;
  logic [NUM_TID-1:0][DATA_W-1:0] regBank;

  tid_decode u_decode (.instr(instr), .fields(fields));

  tid_ctrl u_ctrl (
    .instrValid(instrValid), .fields(fields), .privMode(privMode),
    .featEn(featEn), .ctl(ctl), .undefFlag(undefFlag)
  );

  tid_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .rdData(rdData), .regBank(regBank)
  );
endmodule

// File: rtl/tid_checker.sv
module tid_checker
  import tid_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input logic                           clk,
  input logic                           rstN,
  input logic                           instrValid,
  input logic [31:0]                    instr,
  input logic                           privMode,
  input logic                           featEn,
  input logic [DATA_W-1:0]              wrData,
  input logic [DATA_W-1:0]              rdData,
  input logic                           undefFlag,
  input logic [NUM_TID-1:0][DATA_W-1:0] regBank
);
  logic inBank;
  assign inBank = instrValid && instr[11:8] == 4'd15 && instr[19:16] == 4'd13
                  && instr[3:0] == 4'd0 && instr[23:21] == 3'd0;

  AST_UNDEF_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag |=> $stable(regBank)); // R9
  AST_FEAT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (inBank && !featEn) |-> undefFlag); // R7
  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inBank |-> (!undefFlag && rdData == '0)); // R10
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !inBank |=> $stable(regBank)); // R10
  AST_USER_C_UNDEF: assert property (@(posedge clk) disable iff (!rstN)
    (inBank && !privMode && instr[7:5] == 3'd4) |-> undefFlag); // R5
  AST_BAD_OP2: assert property (@(posedge clk) disable iff (!rstN)
    (inBank && (instr[7:5] < 3'd2 || instr[7:5] > 3'd4)) |-> undefFlag); // R6
  AST_A_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (inBank && featEn && !instr[20] && instr[7:5] == 3'd2) |=> regBank[0] == $past(wrData)); // R3
  AST_UNDEF_RDZERO: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag |-> rdData == '0); // R8
endmodule

bind tid_reg_bank tid_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr),
  .privMode(privMode), .featEn(featEn), .wrData(wrData), .rdData(rdData),
  .undefFlag(undefFlag), .regBank(regBank)
);

// File: tb/tb_tid_reg_bank.sv
`timescale 1ns/1ps
module tb_tid_reg_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instr = '0;
  logic        privMode = 1'b0;
  logic        featEn = 1'b1;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        undefFlag;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [3];
  bit done = 0;

  always #2.5 clk = ~clk;

  tid_reg_bank dut (.*);

  function automatic logic [31:0] mk(input logic [3:0] cp, input logic [3:0] crn,
      input logic [3:0] crm, input logic [2:0] op1, input logic [2:0] op2, input logic rd);
    logic [31:0] w;
    w = 32'hEE000010;
    w[11:8] = cp; w[19:16] = crn; w[3:0] = crm; w[23:21] = op1; w[7:5] = op2; w[20] = rd;
    w[15:12] = 4'd3;
    return w;
  endfunction

  function automatic bit inBank(input logic [31:0] w);
    return w[11:8] == 15 && w[19:16] == 13 && w[3:0] == 0 && w[23:21] == 0;
  endfunction

  function automatic bit permitted(input logic [31:0] w, input bit pv, input bit fe);
    int idx;
    idx = int'(w[7:5]) - 2;
    if (!fe || idx < 0 || idx > 2) return 0;
    if (pv) return 1;
    if (w[20]) return idx != 2;
    return idx == 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] w, input bit pv, input bit fe,
                        input logic [31:0] wd, input string tag);
    bit hit, ok;
    logic [31:0] expRd;
    @(negedge clk);
    instrValid = 1'b1; instr = w; privMode = pv; featEn = fe; wrData = wd;
    hit = inBank(w);
    ok = hit && permitted(w, pv, fe);
    expRd = (ok && w[20]) ? model[int'(w[7:5]) - 2] : 32'h0;
    #1;
    check({tag, " undef"}, {31'b0, undefFlag}, {31'b0, hit && !ok});
    check({tag, " rdData"}, rdData, expRd);
    @(posedge clk);
    if (ok && !w[20]) model[int'(w[7:5]) - 2] = wd;
    #0.5;
    instrValid = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 3; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset values
    for (int i = 2; i <= 4; i++) access(mk(15,13,0,0,3'(i),1), 1, 1, 0, "R1 reset read");
    // R3: register A from user mode
    access(mk(15,13,0,0,2,0), 0, 1, 32'hA5A5_0001, "R3 user write A");
    access(mk(15,13,0,0,2,1), 0, 1, 0, "R3 user read A");
    // R4: register B
    access(mk(15,13,0,0,3,0), 1, 1, 32'hBEEF_0002, "R4 priv write B");
    access(mk(15,13,0,0,3,0), 0, 1, 32'h1111_1111, "R4 user write B refused");
    access(mk(15,13,0,0,3,1), 0, 1, 0, "R4 user read B");
    // R5: register C
    access(mk(15,13,0,0,4,0), 1, 1, 32'hC0DE_0003, "R5 priv write C");
    access(mk(15,13,0,0,4,1), 0, 1, 0, "R5 user read C");
    access(mk(15,13,0,0,4,0), 0, 1, 32'h2222_2222, "R5 user write C");
    access(mk(15,13,0,0,4,1), 1, 1, 0, "R5 priv read C");
    // R6: unused second opcode
    access(mk(15,13,0,0,5,1), 1, 1, 0, "R6 op2 five");
    access(mk(15,13,0,0,1,0), 1, 1, 32'h3333_3333, "R6 op2 one");
    // R7: feature disabled
    access(mk(15,13,0,0,2,0), 1, 0, 32'h4444_4444, "R7 write disabled");
    access(mk(15,13,0,0,2,1), 1, 1, 0, "R7 read after disabled write");
    // R10: outside the bank
    access(mk(14,13,0,0,2,0), 1, 1, 32'h5555_5555, "R10 other coprocessor");
    access(mk(15,12,0,0,2,1), 1, 1, 0, "R10 other crn");
    access(mk(15,13,0,0,2,1), 1, 1, 0, "R10 A unchanged");
    // R8, R9: random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      bit pv, fe;
      int pick;
      pick = $urandom_range(0, 9);
      if (pick < 7) w = mk(15,13,0,0,3'($urandom_range(0, 7) < 6 ? $urandom_range(2, 4)
                                          : $urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      else if (pick < 9) w = mk(4'($urandom_range(13, 15)), 4'($urandom_range(12, 13)),
                                4'($urandom_range(0, 1)), 3'($urandom_range(0, 1)),
                                3'($urandom_range(2, 4)), 1'($urandom_range(0, 1)));
      else w = $urandom;
      pv = 1'($urandom_range(0, 1));
      fe = $urandom_range(0, 7) != 0;
      access(w, pv, fe, $urandom, "R8 R9 random");
    end
    // R2: final direction check on all registers
    for (int i = 2; i <= 4; i++) access(mk(15,13,0,0,3'(i),1), 1, 1, 0, "R2 final read");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule